// File: doc/BRIEF.md
# DRAM Address Multiplexer and Strobe Sequencer

This block sits between a 16-bit CPU bus and a DRAM array built from one or two SIMM rows of either 256K or 1MB parts. When the CPU asks for a DRAM access, the block captures the word address (A1 to A21), the two byte strobes and the transfer direction. It then steps a short cycle sequencer through the row phase, the column phase, the CAS pulse and precharge. The ten multiplexed SIMM address lines, the row/column select, RAS, four byte-lane CAS lines and the RAM write enable all come from the captured request and the sequencer state.

The address bits are deliberately scrambled between the row and column halves. Two configuration straps set how the top SIMM address line is sourced and which CPU address bit picks the second SIMM row. A low level on the external acknowledge override input cancels a request that has not yet reached CAS. This leaves the bus to an expansion card.

Top module: `dram_amux_ctrl`

## Requirements
- R1: In the row phase, RA0 to RA6 carry A2 to A8 in ascending order, RA7 carries A9 and RA8 carries A10.
- R2: In the column phase, RA0 carries A1, RA1 to RA6 carry A11 to A16 in ascending order, RA7 carries A17 and RA8 carries A18.
- R3: With `big_simm` high (1MB parts), RA9 carries A19 in the row phase and A20 in the column phase. With `big_simm` low, RA9 is 0.
- R4: With `two_rows` high, the second CAS pair (`cas1*`) is used when the selector bit is 1 and the first pair (`cas0*`) when it is 0. The selector bit is A19 for 256K parts and A21 for 1MB parts.
- R5: `req` sampled high while idle starts a cycle, with the following timing:
  - One cycle later, `ras_n` is 0 and `col_sel` is 0.
  - Next, `col_sel` is 1.
  - Next, CAS asserts and stays asserted for 1+HOLD_CYC cycles.
  - Then RAS and CAS are released for PRE_CYC cycles before idle.
  - CAS is only ever low while RAS is low and `col_sel` is 1.
- R6: With `two_rows` low, `cas1l_n` and `cas1h_n` never go low, whatever the address.
- R7: The high-byte CAS follows `uds_n` low and the low-byte CAS follows `lds_n` low. Both assert when both strobes are low.
- R8: `we_n` is 0 from the first RAS cycle to the end of the CAS hold for a write (`rw`=0) and 1 for a read. It does not change while CAS is asserted.
- R9: `ext_ack_n` low during the row or column phase cancels the cycle. RAS is released on the next cycle and no CAS asserts. `ext_ack_n` low while idle stops `req` from starting a cycle.
- R10: `ext_ack_n` low once CAS has asserted is ignored, and the cycle completes its full CAS hold.
- R11: After reset, `ras_n`, all CAS lines and `we_n` are 1 and `col_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | CPU DRAM access request |
| cpu_addr | input | 21 | CPU word address A21..A1 |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | 1 read, 0 write |
| big_simm | input | 1 | Strap: 1MB SIMMs fitted |
| two_rows | input | 1 | Strap: second SIMM row fitted |
| ext_ack_n | input | 1 | External acknowledge override, active low |
| ra | output | 10 | Multiplexed SIMM address |
| col_sel | output | 1 | 0 row address, 1 column address |
| ras_n | output | 1 | Row strobe, active low |
| cas0l_n | output | 1 | Row 0 low-byte CAS |
| cas0h_n | output | 1 | Row 0 high-byte CAS |
| cas1l_n | output | 1 | Row 1 low-byte CAS |
| cas1h_n | output | 1 | Row 1 high-byte CAS |
| we_n | output | 1 | RAM write enable, active low |

## Verification
The bench aims at the strap corners: addresses with A19, A20 and A21 set under every strap pair. A swapped selector bit would strobe the wrong SIMM row, and a missing single-row guard would pulse `cas1*` on a board that has no second row. An RA9 that ignored the strap would leak A19 or A20 onto 256K parts.

Overrides are driven in the row phase, the column phase, the CAS phase and while idle. Each one exposes a specific fault:
- A sequencer that reached CAS after a cancel would be caught.
- A sequencer that aborted a cycle already past CAS would be caught.
- A sequencer that started a cycle under an idle override would be caught.

Single-lane accesses catch swapped byte lanes. Random cycles compare every RA bit in both phases against the scramble.

// File: rtl/dram_amux_pkg.sv
package dram_amux_pkg;
   localparam int RA_W   = 10;
   localparam int A_TOP  = 21;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_ROW  = 3'd1,
      SQ_COL  = 3'd2,
      SQ_CAS  = 3'd3,
      SQ_HOLD = 3'd4,
      SQ_PRE  = 3'd5
   } seq_st_e;
endpackage

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
   import dram_amux_pkg::*;
#(
   parameter int HOLD_CYC = 2,
   parameter int PRE_CYC  = 1
)(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req,
   input  logic    ovr_n,
   output seq_st_e st,
   output logic    start
);
   localparam int MAXC  = (HOLD_CYC > PRE_CYC) ? HOLD_CYC : PRE_CYC;
   localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
      if (PRE_CYC < 1) begin : g_bad_pre
         $error("PRE_CYC must be at least 1");
      end
   endgenerate

   seq_st_e          st_nx;
   logic [CNT_W-1:0] cnt, cnt_nx;

   assign start = (st == SQ_IDLE) && req && ovr_n;

   always_comb begin
      st_nx  = st;
      cnt_nx = cnt;
      case (st)
         SQ_IDLE: if (start) st_nx = SQ_ROW;
         SQ_ROW, SQ_COL: begin
            if (!ovr_n) begin
               st_nx  = SQ_PRE;
               cnt_nx = CNT_W'(PRE_CYC - 1);
            end else begin
               st_nx = (st == SQ_ROW) ? SQ_COL : SQ_CAS;
            end
         end
         SQ_CAS: begin
            st_nx  = SQ_HOLD;
            cnt_nx = CNT_W'(HOLD_CYC - 1);
         end
         SQ_HOLD: begin
            if (cnt == '0) begin
               st_nx  = SQ_PRE;
               cnt_nx = CNT_W'(PRE_CYC - 1);
            end else begin
               cnt_nx = cnt - 1'b1;
            end
         end
         SQ_PRE: begin
            if (cnt == '0) st_nx = SQ_IDLE;
            else           cnt_nx = cnt - 1'b1;
         end
         default: st_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         cnt <= '0;
      end else begin
         st  <= st_nx;
         cnt <= cnt_nx;
      end
   end

   AST_CANCEL_BEFORE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SQ_ROW || st == SQ_COL) && !ovr_n) |=> (st == SQ_PRE)); // R9
   AST_CAS_NOT_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_CAS) |=> (st == SQ_HOLD)); // R10
   AST_IDLE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SQ_IDLE) && !ovr_n) |=> (st == SQ_IDLE)); // R9
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
   import dram_amux_pkg::*;
(
   input  logic [20:1]     a,
   input  logic            big,
   input  logic            col_phase,
   output logic [RA_W-1:0] ra
);
   localparam int LOW_LINES = 7;

   logic [RA_W-1:0] row_v, col_v;

   genvar i;
   generate
      for (i = 0; i < LOW_LINES; i++) begin : g_row_low
         assign row_v[i] = a[i + 2];
      end
      assign col_v[0] = a[1];
      for (i = 1; i < LOW_LINES; i++) begin : g_col_low
         assign col_v[i] = a[i + 10];
      end
   endgenerate

   assign row_v[7] = a[9];
   assign row_v[8] = a[10];
   assign row_v[9] = big & a[19];
   assign col_v[7] = a[17];
   assign col_v[8] = a[18];
   assign col_v[9] = big & a[20];

   assign ra = col_phase ? col_v : row_v;
endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
   import dram_amux_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  seq_st_e st,
   input  logic    hi_en,
   input  logic    lo_en,
   input  logic    wr,
   input  logic    bank,
   output logic    ras_n,
   output logic    col_sel,
   output logic    cas0l_n,
   output logic    cas0h_n,
   output logic    cas1l_n,
   output logic    cas1h_n,
   output logic    we_n
);
   logic ras_on, cas_on, act;

   assign ras_on  = (st == SQ_ROW) || (st == SQ_COL) || (st == SQ_CAS) || (st == SQ_HOLD);
   assign cas_on  = (st == SQ_CAS) || (st == SQ_HOLD);
   assign act     = ras_on;

   assign ras_n   = !ras_on;
   assign col_sel = (st == SQ_COL) || cas_on;
   assign cas0l_n = !(cas_on && lo_en && !bank);
   assign cas0h_n = !(cas_on && hi_en && !bank);
   assign cas1l_n = !(cas_on && lo_en &&  bank);
   assign cas1h_n = !(cas_on && hi_en &&  bank);
   assign we_n    = !(act && wr);

   AST_RAS_LEADS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas0l_n || !cas0h_n || !cas1l_n || !cas1h_n) |-> (!ras_n && col_sel && $past(!ras_n))); // R5
   AST_WE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_HOLD) |-> $stable(we_n)); // R8
   AST_ROW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> !col_sel); // R5
endmodule

// File: rtl/dram_amux_ctrl.sv
module dram_amux_ctrl
   import dram_amux_pkg::*;
#(
   parameter int HOLD_CYC = 2,
   parameter int PRE_CYC  = 1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [A_TOP:1]  cpu_addr,
   input  logic            uds_n,
   input  logic            lds_n,
   input  logic            rw,
   input  logic            big_simm,
   input  logic            two_rows,
   input  logic            ext_ack_n,
   output logic [RA_W-1:0] ra,
   output logic            col_sel,
   output logic            ras_n,
   output logic            cas0l_n,
   output logic            cas0h_n,
   output logic            cas1l_n,
   output logic            cas1h_n,
   output logic            we_n
);
   seq_st_e         st;
   logic            start;
   logic [A_TOP:1]  addr_q;
   logic            hi_q, lo_q, wr_q, big_q, two_q, bank_q;
   logic            sel_bit;

   assign sel_bit = big_simm ? cpu_addr[21] : cpu_addr[19];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         hi_q   <= 1'b0;
         lo_q   <= 1'b0;
         wr_q   <= 1'b0;
         big_q  <= 1'b0;
         two_q  <= 1'b0;
         bank_q <= 1'b0;
      end else if (start) begin
         addr_q <= cpu_addr;
         hi_q   <= !uds_n;
         lo_q   <= !lds_n;
         wr_q   <= !rw;
         big_q  <= big_simm;
         two_q  <= two_rows;
         bank_q <= two_rows & sel_bit;
      end
   end

   dram_cycle_seq #(.HOLD_CYC(HOLD_CYC), .PRE_CYC(PRE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .ovr_n(ext_ack_n),
      .st(st), .start(start)
   );

   dram_addr_mux u_mux (
      .a(addr_q[20:1]), .big(big_q), .col_phase(col_sel), .ra(ra)
   );

   dram_strobe_gen u_stb (
      .clk(clk), .rst_n(rst_n), .st(st),
      .hi_en(hi_q), .lo_en(lo_q), .wr(wr_q), .bank(bank_q),
      .ras_n(ras_n), .col_sel(col_sel),
      .cas0l_n(cas0l_n), .cas0h_n(cas0h_n),
      .cas1l_n(cas1l_n), .cas1h_n(cas1h_n), .we_n(we_n)
   );

   AST_ONE_ROW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!two_q) |-> (cas1l_n && cas1h_n)); // R6
   AST_RA9_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!big_q && !ras_n) |-> !ra[9]); // R3
   AST_ONE_ROW_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!cas0l_n || !cas0h_n, !cas1l_n || !cas1h_n})); // R4
endmodule

// File: tb/sim_dram_amux_ctrl.sv
module sim_dram_amux_ctrl;
   localparam int HOLD = 2;
   localparam int PRE  = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [21:1] cpu_addr = '0;
   logic        uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
   logic        big_simm = 1'b0, two_rows = 1'b0, ext_ack_n = 1'b1;
   logic [9:0]  ra;
   logic        col_sel, ras_n, cas0l_n, cas0h_n, cas1l_n, cas1h_n, we_n;

   int n_run = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   dram_amux_ctrl #(.HOLD_CYC(HOLD), .PRE_CYC(PRE)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .cpu_addr(cpu_addr),
      .uds_n(uds_n), .lds_n(lds_n), .rw(rw), .big_simm(big_simm),
      .two_rows(two_rows), .ext_ack_n(ext_ack_n), .ra(ra), .col_sel(col_sel),
      .ras_n(ras_n), .cas0l_n(cas0l_n), .cas0h_n(cas0h_n),
      .cas1l_n(cas1l_n), .cas1h_n(cas1h_n), .we_n(we_n)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [9:0] exp_row(input logic [21:1] a, input logic big);
      logic [9:0] r;
      for (int i = 0; i < 7; i++) r[i] = a[i + 2];
      r[7] = a[9];
      r[8] = a[10];
      r[9] = big & a[19];
      return r;
   endfunction

   function automatic logic [9:0] exp_col(input logic [21:1] a, input logic big);
      logic [9:0] r;
      r[0] = a[1];
      for (int i = 1; i < 7; i++) r[i] = a[i + 10];
      r[7] = a[17];
      r[8] = a[18];
      r[9] = big & a[20];
      return r;
   endfunction

   function automatic logic [3:0] cas_vec();
      return {cas1h_n, cas1l_n, cas0h_n, cas0l_n};
   endfunction

   // ovr_at: 0 none, 1 row phase, 2 column phase, 3 CAS phase
   task automatic run_cycle(input logic [21:1] a, input logic u_n, input logic l_n,
                            input logic rw_i, input logic big_i, input logic two_i,
                            input int ovr_at);
      logic       bank;
      logic [3:0] ecas;
      logic       ewe;
      string      btag;
      bank = two_i & (big_i ? a[21] : a[19]);
      ecas = {!(!u_n && bank), !(!l_n && bank), !(!u_n && !bank), !(!l_n && !bank)};
      ewe  = rw_i;
      btag = two_i ? "R4/R7" : "R6/R7";
      @(negedge clk);
      cpu_addr = a; uds_n = u_n; lds_n = l_n; rw = rw_i;
      big_simm = big_i; two_rows = two_i; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check("R5 ras_n row phase", ras_n, 0);
      check("R5 col_sel row phase", col_sel, 0);
      check("R1 row address", ra[8:0], exp_row(a, big_i) & 10'h1ff);
      check("R3 ra9 row", ra[9], exp_row(a, big_i) >> 9);
      check("R8 we_n row", we_n, ewe);
      check("R5 no cas in row", cas_vec(), 4'hf);
      if (ovr_at == 1) begin
         ext_ack_n = 1'b0;
         @(negedge clk);
         ext_ack_n = 1'b1;
         check("R9 ras released after row cancel", ras_n, 1);
         check("R9 no cas after row cancel", cas_vec(), 4'hf);
         @(negedge clk);
         check("R9 still idle after cancel", cas_vec(), 4'hf);
         return;
      end
      @(negedge clk);
      check("R5 col_sel column phase", col_sel, 1);
      check("R2 column address", ra[8:0], exp_col(a, big_i) & 10'h1ff);
      check("R3 ra9 column", ra[9], exp_col(a, big_i) >> 9);
      check("R5 ras held column", ras_n, 0);
      check("R5 no cas yet", cas_vec(), 4'hf);
      if (ovr_at == 2) begin
         ext_ack_n = 1'b0;
         @(negedge clk);
         ext_ack_n = 1'b1;
         check("R9 ras released after column cancel", ras_n, 1);
         check("R9 no cas after column cancel", cas_vec(), 4'hf);
         @(negedge clk);
         check("R9 still no cas", cas_vec(), 4'hf);
         return;
      end
      @(negedge clk);
      check({btag, " cas lanes"}, cas_vec(), ecas);
      check("R8 we_n at cas", we_n, ewe);
      if (ovr_at == 3) ext_ack_n = 1'b0;
      for (int k = 0; k < HOLD; k++) begin
         @(negedge clk);
         check(ovr_at == 3 ? "R10 cas held under override" : "R5 cas hold", cas_vec(), ecas);
         check("R8 we_n hold", we_n, ewe);
      end
      ext_ack_n = 1'b1;
      for (int k = 0; k < PRE; k++) begin
         @(negedge clk);
         check("R5 precharge ras", ras_n, 1);
         check("R5 precharge cas", cas_vec(), 4'hf);
         check("R8 we_n released", we_n, 1);
      end
      @(negedge clk);
      check("R5 idle ras", ras_n, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R11 ras_n reset", ras_n, 1);
      check("R11 cas reset", cas_vec(), 4'hf);
      check("R11 we_n reset", we_n, 1);
      check("R11 col_sel reset", col_sel, 0);
      rst_n = 1'b1;

      // directed strap corners
      run_cycle(21'h1F_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);   // one row, 256K, all set
      run_cycle(21'h04_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0);   // A19 set, 256K two rows
      run_cycle(21'h10_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 0);   // A21 set, 1MB two rows
      run_cycle(21'h04_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0);   // A19 set, 1MB: row 0
      run_cycle(21'h0C_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0);   // A19/A20, 1MB one row
      run_cycle(21'h00_0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);   // A1 only

      // override corners
      run_cycle(21'h15_5555, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1);
      run_cycle(21'h0A_AAAA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2);
      run_cycle(21'h13_3333, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3);

      // override while idle blocks start (R9)
      @(negedge clk);
      ext_ack_n = 1'b0; req = 1'b1;
      @(negedge clk);
      check("R9 no start under idle override", ras_n, 1);
      @(negedge clk);
      check("R9 still blocked", ras_n, 1);
      req = 1'b0; ext_ack_n = 1'b1;

      for (int t = 0; t < 60; t++) begin
         logic [21:1] a;
         logic [1:0]  lanes;
         a = 21'($urandom());
         lanes = 2'($urandom_range(0, 2));
         run_cycle(a, lanes[1], lanes[0], 1'($urandom()), 1'($urandom()),
                   1'($urandom()), ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 3)) : 0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule